// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This controller brings up four supply rails one at a time in a fixed order and takes them down in the opposite order. Each rail has an enable output. Rail 0 is the negative -4 V charge-pump rail. Rail 1 is the +6 V transceiver regulator. Rail 2 is the +9 V rail. Rail 3 is the +6 V transmit converter. A rail may be sensed in one of two ways. The first is a digital power-good level from a switching converter. The second is a signed ADC sample of its output, qualified against a magnitude window; a parameter picks the way for each rail. The negative rail's sample is negated before the window compare.

A start pulse begins the ramp. Each step waits for the rail just enabled to report good, and only then enables the next rail. A stop pulse ramps the rails down with a programmable spacing between disables. If a rail fails to come up within the step timeout, or if any rail loses good while the block is up, the block shuts down every enabled rail in reverse order. It then holds a fault code naming the rail and the cause until software clears it.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, en_o is 0, state_o is 0 (off), up_o is 0 and fault_o is 0.
- R2: On start_i in the off state, rails are enabled one at a time in the order 0, 1, 2, 3. Rail k+1 is enabled only after rail k reports good, and the enabled set is always a contiguous run starting at rail 0.
- R3: An ADC-sensed rail (default rails 0 and 1) reports good once GOOD_CNT consecutive valid samples have a magnitude within [win_lo_i, win_hi_i]. Any out-of-window valid sample restarts the count. For rail 0 the magnitude is the negated sample, so a positive reading never qualifies. With GOOD_CNT=4, the next rail is enabled GOOD_CNT+1 cycles after an ADC rail is enabled, provided in-window samples arrive every cycle.
- R4: A power-good rail (default rails 2 and 3) uses pgood_i directly. The next rail is enabled one cycle after pgood_i is sampled high.
- R5: If the rail being ramped is not good within step_timeout_i+1 cycles of its enable, a fault is raised at that point. Its enable drops, and fault_code_o becomes {1'b0, rail index}, where bit 2 is the cause (0 = timeout).
- R6: stop_i in the ramp-up or up state disables the enabled rails highest first. Consecutive disables are off_delay_i+1 cycles apart, and the block returns to off with no fault.
- R7: A fault shutdown disables the enabled rails in the same reverse order and with the same spacing as a stop.
- R8: In the up state, a rail that loses good raises a fault with fault_code_o = {1'b1, lowest failing rail index}.
- R9: After a fault shutdown, state_o is 4 (fault), fault_o is 1 and en_o stays 0. start_i and stop_i are ignored. clear_i returns the block to off with fault_code_o = 0.
- R10: up_o is 1 exactly in the up state (state_o = 2), and all four enables are then high. state_o encodes 0 off, 1 ramp-up, 2 up, 3 ramp-down, 4 fault.
- R11: start_i has no effect outside the off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin ramp-up (single-cycle pulse) |
| stop_i | input | 1 | Begin orderly ramp-down |
| clear_i | input | 1 | Clear latched fault |
| pgood_i | input | N_RAILS | Power-good levels, used for non-ADC rails |
| adc_valid_i | input | N_RAILS | Per-rail sample strobe |
| adc_sample_i | input | N_RAILS*ADC_W | Signed samples, rail i at bits [i*ADC_W +: ADC_W] |
| win_lo_i | input | ADC_W | Lower magnitude bound of the good window |
| win_hi_i | input | ADC_W | Upper magnitude bound of the good window |
| step_timeout_i | input | TMR_W | Ramp step timeout count |
| off_delay_i | input | TMR_W | Spacing count between disables |
| en_o | output | N_RAILS | Rail enables, high = on |
| up_o | output | 1 | All rails up |
| fault_o | output | 1 | Fault latched |
| fault_code_o | output | 3 | {cause, rail index} |
| state_o | output | 3 | Sequencer state |

## Verification
On every cycle the assertions check the following. The enables form a contiguous run from rail 0, and at most one enable changes per cycle in either direction. The enables are all low in the off and fault states, and all high whenever up_o is set. A latched fault persists until clear_i and blocks start_i. Only the directed scenarios can show the actual rail order and the exact spacing figures: the GOOD_CNT+1 qualification gap, the single-cycle power-good step, the timeout length and the off_delay_i+1 disable gap. The same holds for the polarity handling of the negative rail, the restarting of the consecutive-sample count, and the contents of the fault code.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_UP    = 3'd1,
    ST_ON    = 3'd2,
    ST_DOWN  = 3'd3,
    ST_FAULT = 3'd4
  } seq_state_e;

  localparam logic CAUSE_TIMEOUT = 1'b0;
  localparam logic CAUSE_LOST    = 1'b1;
endpackage

// File: rtl/rail_adc_qual.sv
module rail_adc_qual #(
  parameter int ADC_W    = 12,
  parameter int GOOD_CNT = 4,
  parameter bit INVERT   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [ADC_W-1:0] sample_i,
  input  logic [ADC_W-1:0] win_lo_i,
  input  logic [ADC_W-1:0] win_hi_i,
  output logic             good_o
);
  localparam int CW = $clog2(GOOD_CNT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(GOOD_CNT);

  logic signed [ADC_W:0] ext, mag, lo, hi;
  logic                  in_win;
  logic [CW-1:0]         cnt_q;

  assign ext    = {sample_i[ADC_W-1], sample_i};
  assign mag    = INVERT ? -ext : ext;  // negative rail compared on magnitude
  assign lo     = {1'b0, win_lo_i};
  assign hi     = {1'b0, win_hi_i};
  assign in_win = (mag >= lo) && (mag <= hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!en_i)                cnt_q <= '0;
    else if (valid_i) begin
      if (!in_win)                 cnt_q <= '0;
      else if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign good_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int N  = 4,
  parameter int TW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         clear_i,
  input  logic [N-1:0] good_i,
  input  logic [TW-1:0] timeout_i,
  input  logic [TW-1:0] delay_i,
  output logic [N-1:0] en_o,
  output seq_state_e   state_o,
  output logic [IW:0]  code_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  seq_state_e    state_q;
  logic [IW-1:0] idx_q, lost_idx;
  logic [TW-1:0] tmr_q;
  logic [N-1:0]  en_q;
  logic [IW:0]   code_q;
  logic          fpend_q, any_lost;

  always_comb begin
    lost_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!good_i[i]) lost_idx = IW'(i);
    end
    any_lost = ~&good_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      idx_q   <= '0;
      tmr_q   <= '0;
      en_q    <= '0;
      code_q  <= '0;
      fpend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: if (start_i) begin
          state_q <= ST_UP;
          idx_q   <= '0;
          tmr_q   <= '0;
          en_q    <= N'(1);
        end
        ST_UP: begin
          if (!good_i[idx_q] && tmr_q == timeout_i) begin
            code_q       <= {CAUSE_TIMEOUT, idx_q};
            fpend_q      <= 1'b1;
            state_q      <= ST_DOWN;
            en_q[idx_q]  <= 1'b0;
            tmr_q        <= '0;
          end else if (stop_i) begin
            state_q      <= ST_DOWN;
            en_q[idx_q]  <= 1'b0;
            tmr_q        <= '0;
          end else if (good_i[idx_q]) begin
            if (idx_q == LAST) state_q <= ST_ON;
            else begin
              idx_q                     <= idx_q + 1'b1;
              en_q[IW'(idx_q + 1'b1)]   <= 1'b1;
              tmr_q                     <= '0;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_ON: begin
          if (any_lost || stop_i) begin
            if (any_lost) begin
              code_q  <= {CAUSE_LOST, lost_idx};
              fpend_q <= 1'b1;
            end
            state_q    <= ST_DOWN;
            idx_q      <= LAST;
            en_q[LAST] <= 1'b0;
            tmr_q      <= '0;
          end
        end
        ST_DOWN: begin
          if (tmr_q == delay_i) begin
            tmr_q <= '0;
            if (idx_q == '0) begin
              state_q <= fpend_q ? ST_FAULT : ST_OFF;
              fpend_q <= 1'b0;
            end else begin
              idx_q                   <= idx_q - 1'b1;
              en_q[IW'(idx_q - 1'b1)] <= 1'b0;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_FAULT: if (clear_i) begin
          state_q <= ST_OFF;
          code_q  <= '0;
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign en_o    = en_q;
  assign state_o = state_q;
  assign code_o  = code_q;
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int          N_RAILS  = 4,
  parameter int          ADC_W    = 12,
  parameter int          GOOD_CNT = 4,
  parameter int          TMR_W    = 16,
  parameter logic [3:0]  ADC_MASK = 4'b0011,
  parameter logic [3:0]  INV_MASK = 4'b0001,
  localparam int         IW       = $clog2(N_RAILS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       stop_i,
  input  logic                       clear_i,
  input  logic [N_RAILS-1:0]         pgood_i,
  input  logic [N_RAILS-1:0]         adc_valid_i,
  input  logic [N_RAILS*ADC_W-1:0]   adc_sample_i,
  input  logic [ADC_W-1:0]           win_lo_i,
  input  logic [ADC_W-1:0]           win_hi_i,
  input  logic [TMR_W-1:0]           step_timeout_i,
  input  logic [TMR_W-1:0]           off_delay_i,
  output logic [N_RAILS-1:0]         en_o,
  output logic                       up_o,
  output logic                       fault_o,
  output logic [IW:0]                fault_code_o,
  output logic [2:0]                 state_o
);
  logic [N_RAILS-1:0] adc_good, rail_good;
  seq_state_e         state;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    rail_adc_qual #(
      .ADC_W   (ADC_W),
      .GOOD_CNT(GOOD_CNT),
      .INVERT  (INV_MASK[i])
    ) u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_o[i]),
      .valid_i (adc_valid_i[i]),
      .sample_i(adc_sample_i[i*ADC_W +: ADC_W]),
      .win_lo_i(win_lo_i),
      .win_hi_i(win_hi_i),
      .good_o  (adc_good[i])
    );
    assign rail_good[i] = ADC_MASK[i] ? adc_good[i] : pgood_i[i];
  end

  rail_seq_fsm #(
    .N (N_RAILS),
    .TW(TMR_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .clear_i  (clear_i),
    .good_i   (rail_good),
    .timeout_i(step_timeout_i),
    .delay_i  (off_delay_i),
    .en_o     (en_o),
    .state_o  (state),
    .code_o   (fault_code_o)
  );

  assign state_o = state;
  assign up_o    = (state == ST_ON);
  assign fault_o = (state == ST_FAULT);
endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         clear_i,
  input logic [N-1:0] en_o,
  input logic         up_o,
  input logic         fault_o,
  input logic [2:0]   state_o
);
  logic [N-1:0] en_inc;
  assign en_inc = en_o + 1'b1;

  a_r2_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_inc & en_o) == '0);

  a_r2_one_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en_o) <= $countones($past(en_o)) + 1);

  a_r6_one_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en_o) + 1 >= $countones($past(en_o)));

  a_r9_fault_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> en_o == '0);

  a_r9_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clear_i) |=> fault_o);

  a_r9_start_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && start_i && !clear_i) |=> en_o == '0);

  a_r10_up_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> &en_o);

  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) |-> en_o == '0);
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk #(.N(N_RAILS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .clear_i(clear_i),
  .en_o   (en_o),
  .up_o   (up_o),
  .fault_o(fault_o),
  .state_o(state_o)
);

// File: tb/rail_seq_ctrl_test.sv
`timescale 1ns/1ps
module rail_seq_ctrl_test;
  localparam int N = 4, AW = 12, GC = 4, TW = 16;
  localparam int T_OUT = 40, D_OFF = 5;

  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, clear = 0;
  logic [N-1:0] pgood = '0, valid = '0, en;
  logic [N*AW-1:0] samples = '0;
  logic up, fault;
  logic [2:0] code, state;

  always #5 clk = ~clk;

  rail_seq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .clear_i(clear),
    .pgood_i(pgood), .adc_valid_i(valid), .adc_sample_i(samples),
    .win_lo_i(12'd300), .win_hi_i(12'd900),
    .step_timeout_i(TW'(T_OUT)), .off_delay_i(TW'(D_OFF)),
    .en_o(en), .up_o(up), .fault_o(fault), .fault_code_o(code), .state_o(state));

  int errors = 0, checks = 0;
  int mode [N];          // 0 healthy, 1 wrong polarity, 2 over window, 3 flicker, 4 dead
  int scnt [N];
  int cyc = 0;
  int rise_n, fall_n;
  int rise_rail [16], rise_cyc [16], fall_rail [16], fall_cyc [16];
  logic [N-1:0] en_prev = '0;

  initial for (int i = 0; i < N; i++) begin mode[i] = 0; scnt[i] = 0; end

  // rail models
  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      logic signed [AW-1:0] v;
      int nom;
      nom = (i == 0) ? -400 : 600;
      valid[i] = 1'b1;
      if (!en[i]) begin v = '0; scnt[i] = 0; end
      else begin
        case (mode[i])
          0: v = AW'(nom);
          1: v = AW'(-nom);
          2: v = AW'((i == 0) ? -1000 : 1000);
          3: v = (scnt[i] % 4 == 3) ? '0 : AW'(nom);
          default: v = '0;
        endcase
        scnt[i]++;
      end
      samples[i*AW +: AW] = v;
      pgood[i] = en[i] && (mode[i] == 0);
    end
  end

  // enable event log
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < N; i++) begin
      if (en[i] && !en_prev[i] && rise_n < 16) begin
        rise_rail[rise_n] = i; rise_cyc[rise_n] = cyc; rise_n++;
      end
      if (!en[i] && en_prev[i] && fall_n < 16) begin
        fall_rail[fall_n] = i; fall_cyc[fall_n] = cyc; fall_n++;
      end
    end
    en_prev = en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clear_log();
    rise_n = 0; fall_n = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  task automatic wait_state(input logic [2:0] st, input int max);
    for (int k = 0; k < max && state != st; k++) step(1);
  endtask

  task automatic ramp_up();
    clear_log();
    pulse(start);
    wait_state(3'd2, 500);
  endtask

  task automatic check_down_order(input string req, input int first);
    chk(fall_n == first + 1, req, fall_n, first + 1);
    for (int k = 0; k <= first && k < fall_n; k++) begin
      chk(fall_rail[k] == first - k, req, fall_rail[k], first - k);
      if (k > 0) chk(fall_cyc[k] - fall_cyc[k-1] == D_OFF + 1, req,
                     fall_cyc[k] - fall_cyc[k-1], D_OFF + 1);
    end
  endtask

  task automatic t_reset();
    chk(en == '0, "R1 en", int'(en), 0);
    chk(state == 3'd0, "R1 state", int'(state), 0);
    chk(!up && !fault, "R1 flags", int'({up, fault}), 0);
  endtask

  task automatic t_power_up();
    ramp_up();
    chk(up == 1'b1, "R10 up", int'(up), 1);
    chk(en == 4'hF, "R10 en", int'(en), 15);
    chk(rise_n == 4, "R2 count", rise_n, 4);
    for (int k = 0; k < 4 && k < rise_n; k++)
      chk(rise_rail[k] == k, "R2 order", rise_rail[k], k);
    if (rise_n == 4) begin
      chk(rise_cyc[1] - rise_cyc[0] == GC + 1, "R3 qual gap", rise_cyc[1] - rise_cyc[0], GC + 1);
      chk(rise_cyc[2] - rise_cyc[1] == GC + 1, "R3 qual gap", rise_cyc[2] - rise_cyc[1], GC + 1);
      chk(rise_cyc[3] - rise_cyc[2] == 1, "R4 pgood gap", rise_cyc[3] - rise_cyc[2], 1);
    end
    pulse(start); step(10);
    chk(state == 3'd2 && en == 4'hF, "R11 start in up", int'(state), 2);
  endtask

  task automatic t_stop();
    clear_log();
    pulse(stop);
    step(4 * (D_OFF + 1) + 5);
    check_down_order("R6 stop order", 3);
    chk(state == 3'd0 && !fault, "R6 end off", int'(state), 0);
  endtask

  task automatic t_stop_midramp();
    clear_log();
    pulse(start);
    for (int k = 0; k < 100 && rise_n < 2; k++) step(1);
    pulse(stop);
    step(2 * (D_OFF + 1) + 5);
    check_down_order("R6 mid-ramp", 1);
    chk(state == 3'd0 && !fault, "R6 mid-ramp off", int'(state), 0);
  endtask

  task automatic t_lost();
    ramp_up();
    clear_log();
    mode[2] = 4;
    step(4 * (D_OFF + 1) + 5);
    check_down_order("R7 fault order", 3);
    chk(state == 3'd4 && fault, "R9 fault state", int'(state), 4);
    chk(code == 3'b110, "R8 code", int'(code), 6);
    mode[2] = 0;
    clear_log();
    pulse(start); pulse(stop); step(20);
    chk(en == '0 && rise_n == 0, "R9 start ignored", int'(en), 0);
    chk(state == 3'd4, "R9 held", int'(state), 4);
    pulse(clear); step(1);
    chk(state == 3'd0 && !fault && code == '0, "R9 clear", int'(code), 0);
  endtask

  task automatic t_timeout(input int rail, input int m, input string req);
    mode[rail] = m;
    clear_log();
    pulse(start);
    step((rail + 1) * (T_OUT + 10) + 4 * (D_OFF + 1) + 10);
    chk(state == 3'd4, req, int'(state), 4);
    chk(code == 3'(rail), req, int'(code), rail);
    chk(rise_n == rail + 1, req, rise_n, rail + 1);
    if (rise_n == rail + 1 && fall_n > 0)
      chk(fall_cyc[0] - rise_cyc[rail] == T_OUT + 1, "R5 timeout len",
          fall_cyc[0] - rise_cyc[rail], T_OUT + 1);
    mode[rail] = 0;
    pulse(clear); step(1);
  endtask

  initial begin
    #(2_000_000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rise_n = 0; fall_n = 0;
    step(3);
    t_reset();
    rst_n = 1;
    step(2);
    t_reset();
    t_power_up();
    t_stop();
    t_stop_midramp();
    t_lost();
    t_timeout(0, 1, "R3 polarity R5");
    t_timeout(1, 2, "R3 window R5");
    t_timeout(1, 3, "R3 consecutive R5");
    ramp_up();
    chk(up == 1'b1, "R2 recovery", int'(up), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule